// File: doc/BRIEF.md
# Mode-Selected 32-bit Integer ALU

This block is a purely combinational integer arithmetic and logic unit for a processor execute stage. Two 32-bit operands and a 4-bit mode code enter; a 32-bit result, a carry flag and an overflow flag leave. No clock, reset or state is involved. The outputs follow the inputs within the same cycle, so the surrounding pipeline registers both sides.

One adder serves every arithmetic mode. An operand stage either passes the second operand through or inverts it and forces a carry-in of one, which turns the adder into a subtractor. The two compare modes reuse that subtract path. Signed compare uses the sign of the difference corrected by the signed overflow term. Unsigned compare uses the borrow, which is the absence of a carry out. The four bitwise operations come from a separate logic unit, and a final multiplexer picks the result and flags by mode.

Overflow is only a flag. Only the signed add and signed subtract modes can raise it. No trap or exception is generated here.

Top module: `int_alu32`

## Requirements
- R1: Mode 0 (signed add): the result is (A + B) mod 2^32. Carry is the carry out of bit 31. Overflow is 1 exactly when A and B have the same sign and the result has the other sign.
- R2: Mode 1 (unsigned add): the result and carry are the same as in mode 0, and overflow is always 0.
- R3: Mode 2 (signed subtract): the result is (A + ~B + 1) mod 2^32. Carry is the carry out of bit 31 of that sum, so 1 means no borrow. Overflow is 1 exactly when A and B differ in sign and the result's sign differs from A's.
- R4: Mode 3 (unsigned subtract): the result and carry are the same as in mode 2, and overflow is always 0.
- R5: Modes 4, 5, 6 and 7 return A AND B, A OR B, A XOR B and NOR(A, B) in that order. Carry and overflow are both 0.
- R6: Mode 8 (signed less-than): result bit 0 is 1 when A < B as two's-complement numbers, and this holds even when A - B overflows. Bits 31 to 1 are 0. Carry is the subtract carry out and overflow is 0.
- R7: Mode 9 (unsigned less-than): result bit 0 is 1 when A < B as unsigned numbers, which is the case when the subtract has no carry out. Bits 31 to 1 are 0. Carry is the subtract carry out and overflow is 0.
- R8: Mode codes 10 to 15 return a zero result with carry 0 and overflow 0.
- R9: In mode 0, operands of opposite sign never raise overflow. In mode 2, operands of equal sign never raise overflow.
- R10: All three outputs depend only on the present inputs and are valid in the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| mode_i | input | 4 | Operation select, encoded as listed in R1 to R8 |
| result_o | output | 32 | Operation result |
| carry_o | output | 1 | Adder carry out for arithmetic and compare modes, else 0 |
| ovf_o | output | 1 | Signed overflow for modes 0 and 2, else 0 |

## Verification
Every result is due zero cycles after its stimulus because the block has no registers. The bench applies a new operand and mode set just after a rising edge and compares all three outputs against its behavioural model at the next falling edge, half a period later. Directed vectors cover the overflow boundaries at the most positive and most negative values, compares whose difference overflows, the borrow cases and the unused codes. A long run of pseudo-random vectors over all sixteen codes follows.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int unsigned MODE_W = 4;

  localparam logic [MODE_W-1:0] MD_ADD  = 4'd0;
  localparam logic [MODE_W-1:0] MD_ADDU = 4'd1;
  localparam logic [MODE_W-1:0] MD_SUB  = 4'd2;
  localparam logic [MODE_W-1:0] MD_SUBU = 4'd3;
  localparam logic [MODE_W-1:0] MD_AND  = 4'd4;
  localparam logic [MODE_W-1:0] MD_OR   = 4'd5;
  localparam logic [MODE_W-1:0] MD_XOR  = 4'd6;
  localparam logic [MODE_W-1:0] MD_NOR  = 4'd7;
  localparam logic [MODE_W-1:0] MD_SLT  = 4'd8;
  localparam logic [MODE_W-1:0] MD_SLTU = 4'd9;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_sel_e;

  function automatic logic uses_subtract(input logic [MODE_W-1:0] md);
    return (md == MD_SUB) || (md == MD_SUBU) || (md == MD_SLT) || (md == MD_SLTU);
  endfunction

  function automatic logic is_logic_mode(input logic [MODE_W-1:0] md);
    return (md >= MD_AND) && (md <= MD_NOR);
  endfunction

endpackage

// File: rtl/alu_operand_stage.sv
module alu_operand_stage #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] b_i,
  input  logic         sub_en_i,
  output logic [W-1:0] b_eff_o,
  output logic         cin_o
);
  // Subtraction as A + ~B + 1: the inversion and the injected carry together.
  always_comb begin
    b_eff_o = sub_en_i ? ~b_i : b_i;
    cin_o   = sub_en_i;
  end

  always_comb begin
    // R3: when subtracting, the adder input plus the carry-in is the negated operand
    p_negate_r3: assert (!sub_en_i || ((b_eff_o + {{(W-1){1'b0}}, cin_o}) == (~b_i + 1'b1)));
  end
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         cmsb_o
);
  logic [W:0] chain;

  assign chain[0] = cin_i;

  for (genvar k = 0; k < W; k++) begin : g_bit
    logic gen_k;
    logic prop_k;
    assign gen_k      = a_i[k] & b_i[k];
    assign prop_k     = a_i[k] ^ b_i[k];
    assign sum_o[k]   = prop_k ^ chain[k];
    assign chain[k+1] = gen_k | (prop_k & chain[k]);
  end

  assign cout_o = chain[W];
  assign cmsb_o = chain[W-1];

  always_comb begin
    // R1: the bit chain agrees with a behavioural sum including carry out
    p_sum_r1: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}));
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import int_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_sel_e   sel_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    case (sel_i)
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end

  always_comb begin
    // R5: NOR and OR outputs are bitwise complements for the same operands
    p_nor_or_r5: assert ((sel_i != LG_NOR) || ((y_o ^ (a_i | b_i)) == {W{1'b1}}));
  end
endmodule

// File: rtl/alu_compare_unit.sv
module alu_compare_unit (
  input  logic sum_msb_i,
  input  logic cmsb_i,
  input  logic cout_i,
  output logic ovf_o,
  output logic lt_s_o,
  output logic lt_u_o
);
  always_comb begin
    ovf_o  = cmsb_i ^ cout_i;
    lt_s_o = sum_msb_i ^ ovf_o;
    lt_u_o = ~cout_i;
  end
endmodule

// File: rtl/int_alu32.sv
module int_alu32
  import int_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [W-1:0]      result_o,
  output logic              carry_o,
  output logic              ovf_o
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] b_eff;
  logic         cin;
  logic [W-1:0] sum;
  logic         cout;
  logic         cmsb;
  logic         ovf_raw;
  logic         lt_s;
  logic         lt_u;
  logic [W-1:0] logic_y;
  logic_sel_e   lsel;

  assign lsel = logic_sel_e'(mode_i[1:0]);

  alu_operand_stage #(.W(W)) u_opnd (
    .b_i      (b_i),
    .sub_en_i (uses_subtract(mode_i)),
    .b_eff_o  (b_eff),
    .cin_o    (cin)
  );

  alu_ripple_adder #(.W(W)) u_add (
    .a_i    (a_i),
    .b_i    (b_eff),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout),
    .cmsb_o (cmsb)
  );

  alu_compare_unit u_cmp (
    .sum_msb_i (sum[MSB]),
    .cmsb_i    (cmsb),
    .cout_i    (cout),
    .ovf_o     (ovf_raw),
    .lt_s_o    (lt_s),
    .lt_u_o    (lt_u)
  );

  alu_logic_unit #(.W(W)) u_log (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (lsel),
    .y_o   (logic_y)
  );

  always_comb begin
    result_o = '0;
    carry_o  = 1'b0;
    ovf_o    = 1'b0;
    case (mode_i)
      MD_ADD, MD_SUB: begin
        result_o = sum;
        carry_o  = cout;
        ovf_o    = ovf_raw;
      end
      MD_ADDU, MD_SUBU: begin
        result_o = sum;
        carry_o  = cout;
      end
      MD_AND, MD_OR, MD_XOR, MD_NOR: begin
        result_o = logic_y;
      end
      MD_SLT: begin
        result_o = {{(W-1){1'b0}}, lt_s};
        carry_o  = cout;
      end
      MD_SLTU: begin
        result_o = {{(W-1){1'b0}}, lt_u};
        carry_o  = cout;
      end
      default: ;
    endcase
  end

  always_comb begin
    // R9: opposite-sign add and same-sign subtract never overflow
    p_no_overflow_r9: assert (!(ovf_o &&
      (((mode_i == MD_ADD) && (a_i[MSB] != b_i[MSB])) ||
       ((mode_i == MD_SUB) && (a_i[MSB] == b_i[MSB])))));
    // R2: unsigned add keeps overflow low
    p_no_overflow_r2: assert (!((mode_i == MD_ADDU) && ovf_o));
    // R4: unsigned subtract keeps overflow low
    p_no_overflow_r4: assert (!((mode_i == MD_SUBU) && ovf_o));
    // R5: logic modes clear both flags
    p_logic_flags_r5: assert (!(is_logic_mode(mode_i) && (carry_o || ovf_o)));
    // R6: signed compare leaves upper bits clear and no overflow
    p_slt_shape_r6: assert (!((mode_i == MD_SLT) && ((result_o[MSB:1] != '0) || ovf_o)));
    // R7: unsigned compare answer is the borrow, i.e. inverse of carry
    p_sltu_borrow_r7: assert (!((mode_i == MD_SLTU) &&
      ((result_o[MSB:1] != '0) || (result_o[0] == carry_o) || ovf_o)));
    // R8: unused codes give all-zero outputs
    p_unused_zero_r8: assert (!((mode_i > MD_SLTU) && ((result_o != '0) || carry_o || ovf_o)));
  end
endmodule

// File: tb/test_int_alu32.sv
module test_int_alu32;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic [3:0]  mode = '0;
  logic [31:0] result;
  logic        carry;
  logic        ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  int_alu32 i_int_alu32 (
    .a_i      (a),
    .b_i      (b),
    .mode_i   (mode),
    .result_o (result),
    .carry_o  (carry),
    .ovf_o    (ovf)
  );

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4, 4'd5, 4'd6, 4'd7: return "R5";
      4'd8: return "R6";
      4'd9: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Behavioural reference from the requirement text, using wide integers.
  task automatic model(input logic [31:0] x, input logic [31:0] y, input logic [3:0] m,
                       output logic [31:0] r, output logic c, output logic v);
    longint unsigned ux = longint'(x);
    longint unsigned uy = longint'(y);
    longint signed   sx = longint'($signed(x));
    longint signed   sy = longint'($signed(y));
    longint unsigned s;
    longint signed   d;
    r = '0; c = 1'b0; v = 1'b0;
    case (m)
      4'd0, 4'd1: begin
        s = ux + uy;
        r = s[31:0];
        c = s[32];
        d = sx + sy;
        if (m == 4'd0) v = (d > 64'sd2147483647) || (d < -64'sd2147483648);
      end
      4'd2, 4'd3, 4'd8, 4'd9: begin
        s = ux + (64'h0_FFFF_FFFF - uy) + 64'd1;
        c = s[32];
        d = sx - sy;
        if (m == 4'd2) v = (d > 64'sd2147483647) || (d < -64'sd2147483648);
        if (m <= 4'd3) r = s[31:0];
        else if (m == 4'd8) r = {31'd0, sx < sy};
        else r = {31'd0, ux < uy};
      end
      4'd4: r = x & y;
      4'd5: r = x | y;
      4'd6: r = x ^ y;
      4'd7: r = ~(x | y);
      default: ;
    endcase
  endtask

  task automatic apply_and_check(input logic [31:0] x, input logic [31:0] y,
                                 input logic [3:0] m, input string tag);
    logic [31:0] er;
    logic ec;
    logic ev;
    string t;
    @(posedge clk);
    #1;
    a = x; b = y; mode = m;
    model(x, y, m, er, ec, ev);
    t = (tag == "") ? tag_of(m) : tag;
    @(negedge clk);
    checks++;
    if (result !== er || carry !== ec || ovf !== ev) begin
      errors++;
      $display("FAIL %s mode=%0d a=%h b=%h actual r=%h c=%b v=%b expected r=%h c=%b v=%b",
               t, m, x, y, result, carry, ovf, er, ec, ev);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R1: idle inputs (all zero, mode 0) give zero outputs
    apply_and_check(32'h0, 32'h0, 4'd0, "R1");
    // R1: positive overflow and negative overflow with carry
    apply_and_check(32'h7FFF_FFFF, 32'h1, 4'd0, "R1");
    apply_and_check(32'h8000_0000, 32'h8000_0000, 4'd0, "R1");
    apply_and_check(32'hFFFF_FFFF, 32'h1, 4'd0, "R1");
    // R9: opposite signs on add, equal signs on subtract never overflow
    apply_and_check(32'h7FFF_FFFF, 32'h8000_0000, 4'd0, "R9");
    apply_and_check(32'h8000_0000, 32'hFFFF_FFFF, 4'd2, "R9");
    apply_and_check(32'h7FFF_FFFF, 32'h0000_0001, 4'd2, "R9");
    // R2: same sum as mode 0, no overflow
    apply_and_check(32'h7FFF_FFFF, 32'h1, 4'd1, "R2");
    apply_and_check(32'h8000_0000, 32'h8000_0000, 4'd1, "R2");
    // R3: signed subtract overflow in both directions
    apply_and_check(32'h8000_0000, 32'h1, 4'd2, "R3");
    apply_and_check(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd2, "R3");
    apply_and_check(32'h5, 32'h5, 4'd2, "R3");
    // R4: borrow gives carry 0, no overflow
    apply_and_check(32'h0, 32'h1, 4'd3, "R4");
    apply_and_check(32'h8000_0000, 32'h1, 4'd3, "R4");
    // R5: each logic function
    apply_and_check(32'hF0F0_1234, 32'h0FF0_FF00, 4'd4, "R5");
    apply_and_check(32'hF0F0_1234, 32'h0FF0_FF00, 4'd5, "R5");
    apply_and_check(32'hF0F0_1234, 32'h0FF0_FF00, 4'd6, "R5");
    apply_and_check(32'hF0F0_1234, 32'h0FF0_FF00, 4'd7, "R5");
    // R6: compares whose difference overflows
    apply_and_check(32'h8000_0000, 32'h7FFF_FFFF, 4'd8, "R6");
    apply_and_check(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd8, "R6");
    apply_and_check(32'hFFFF_FFFF, 32'h0, 4'd8, "R6");
    apply_and_check(32'h3, 32'h3, 4'd8, "R6");
    // R7: unsigned compare at the extremes
    apply_and_check(32'hFFFF_FFFF, 32'h1, 4'd9, "R7");
    apply_and_check(32'h1, 32'hFFFF_FFFF, 4'd9, "R7");
    apply_and_check(32'h9, 32'h9, 4'd9, "R7");
    // R8: every unused code with operands that would set flags
    for (int k = 10; k < 16; k++)
      apply_and_check(32'h8000_0000, 32'h8000_0000, 4'(k), "R8");
    // R10: outputs settle in the same cycle as back-to-back changes
    apply_and_check(32'hDEAD_BEEF, 32'h1234_5678, 4'd0, "R10");
    apply_and_check(32'hDEAD_BEEF, 32'h1234_5678, 4'd2, "R10");
    // Pseudo-random sweep over all codes
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] rx;
      logic [31:0] ry;
      rx = $urandom;
      ry = $urandom;
      if (n % 7 == 0) ry = rx;
      if (n % 11 == 0) rx = {rx[31], 31'h7FFF_FFFF};
      apply_and_check(rx, ry, 4'($urandom_range(0, 15)), "");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R10 actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule